// File: doc/BRIEF.md
# Serial Gain-Code Programming Register

This block accepts a gain setting from a three-wire serial port: a serial clock, an active-low frame enable and a data line. All three lines are sampled on the system clock through synchronizers. Data moves in only during a frame, when the enable line is low. Each rising edge of the serial clock shifts one bit into a six-bit register, most significant bit first. Words longer than six bits are accepted, and only their last six bits are kept.

When the enable line goes high, the captured code is range-limited and loaded into the active gain register. Code 0 becomes 1, and codes 61 to 63 become 60. The block then presents the effective code and a signed gain in half-decibel steps. One code step is one decibel, so code 1 gives -25.5 dB and code 60 gives +33.5 dB. A one-cycle pulse marks every load, so that downstream gain hardware can retime its change.

Top module: `serial_gain_reg`

## Requirements
- R1: Serial clock edges that occur while the enable line is high do not change the captured word. An empty frame (enable low then high with no clock edges) afterwards reloads the previously captured code.
- R2: Each rising edge of the serial clock during a frame shifts the data line in, first bit sent = most significant bit of the code.
- R3: When more than six bits are sent in a frame, only the last six bits are kept; an 8-bit word 75 (01001011) yields code 11.
- R4: A captured code in the range 1 to 60 becomes the effective gain code unchanged.
- R5: Captured codes 61, 62 and 63 produce effective code 60.
- R6: Captured code 0 produces effective code 1.
- R7: The gain output is a signed 8-bit two's complement value equal to 2 × code − 53 (half-dB units): −51 for code 1, +67 for code 60.
- R8: The effective code does not change during a frame. It loads 3 system clocks after the enable line rises (2 synchronizer stages plus 1 register), and is unchanged 2 clocks after that rise.
- R9: Synchronous active-high reset sets the effective code to 1, the gain output to −51 and the update pulse to 0.
- R10: The update output is high for exactly one system clock cycle, the cycle in which the new effective code first appears, for every load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to clk |
| ser_en_n | input | 1 | Active-low frame enable; rising edge loads the code |
| ser_data | input | 1 | Serial data, sampled on rising ser_clk |
| gain_code | output | 6 | Effective gain code, 1 to 60 |
| gain_halfdb | output | 8 | Signed gain in half-dB units |
| gain_upd | output | 1 | One-cycle pulse when the active gain is loaded |

## Verification
A serial line change is seen by the logic after two synchronizer stages, and the register it feeds updates on the third system clock edge after the change. The new effective code, its half-dB value and the update pulse therefore all appear 3 clocks after the enable line rises. The bench drives every line on the falling clock edge. It samples on falling edges, expecting the old code at the second edge and the new code with the pulse at the third. It checks that the pulse has dropped again at the fourth. During frames it checks at every bit that the effective code has not moved.

// File: rtl/gain_pkg.sv
package gain_pkg;
    localparam int CODE_W       = 6;
    localparam int GAIN_W       = 8;
    localparam int MIN_CODE     = 1;
    localparam int MAX_CODE     = 60;
    localparam int HALF_DB_BIAS = 53;

    typedef logic [CODE_W-1:0]        code_t;
    typedef logic signed [GAIN_W-1:0] halfdb_t;

    typedef struct packed {
        logic sck;
        logic sen_n;
        logic sdi;
    } ser_lines_t;

    localparam ser_lines_t SER_IDLE = '{sck: 1'b0, sen_n: 1'b1, sdi: 1'b0};

    typedef struct packed {
        logic  load;
        code_t raw;
    } capture_t;

    function automatic code_t limit_code(code_t raw);
        if (int'(raw) < MIN_CODE) return code_t'(MIN_CODE);
        if (int'(raw) > MAX_CODE) return code_t'(MAX_CODE);
        return raw;
    endfunction

    function automatic halfdb_t code_to_halfdb(code_t c);
        return halfdb_t'(2 * int'(c) - HALF_DB_BIAS);
    endfunction
endpackage

// File: rtl/gs_sync.sv
module gs_sync #(
    parameter int                      W       = 3,
    parameter int                      STAGES  = 2,
    parameter logic [W-1:0]            RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= RST_VAL;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= RST_VAL;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gs_shifter.sv
module gs_shifter
    import gain_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ser_lines_t lines,
    output capture_t   cap
);
    ser_lines_t prev;
    code_t      shreg;
    logic       sck_rise;
    logic       sen_rise;

    always_ff @(posedge clk) begin
        if (rst) prev <= SER_IDLE;
        else     prev <= lines;
    end

    assign sck_rise = lines.sck && !prev.sck;
    assign sen_rise = lines.sen_n && !prev.sen_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (sck_rise && !lines.sen_n) begin
            shreg <= {shreg[CODE_W-2:0], lines.sdi};
        end
    end

    assign cap.load = sen_rise;
    assign cap.raw  = shreg;

    // R1: outside a frame the captured word is frozen
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
        lines.sen_n |=> $stable(shreg));
endmodule

// File: rtl/gs_gain_map.sv
module gs_gain_map
    import gain_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  capture_t cap,
    output code_t    code,
    output halfdb_t  halfdb,
    output logic     upd
);
    code_t next_code;

    assign next_code = limit_code(cap.raw);

    always_ff @(posedge clk) begin
        if (rst) begin
            code   <= code_t'(MIN_CODE);
            halfdb <= code_to_halfdb(code_t'(MIN_CODE));
            upd    <= 1'b0;
        end else begin
            upd <= cap.load;
            if (cap.load) begin
                code   <= next_code;
                halfdb <= code_to_halfdb(next_code);
            end
        end
    end

    p_code_range_r5: assert property (@(posedge clk) disable iff (rst)
        (int'(code) >= MIN_CODE) && (int'(code) <= MAX_CODE));
    p_halfdb_match_r7: assert property (@(posedge clk) disable iff (rst)
        halfdb == code_to_halfdb(code));
    p_hold_no_load_r8: assert property (@(posedge clk) disable iff (rst)
        !cap.load |=> $stable(code));
    p_pulse_on_load_r10: assert property (@(posedge clk) disable iff (rst)
        cap.load |=> upd);
    p_pulse_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !cap.load |=> !upd);
endmodule

// File: rtl/serial_gain_reg.sv
module serial_gain_reg
    import gain_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_en_n,
    input  logic              ser_data,
    output logic [CODE_W-1:0] gain_code,
    output logic [GAIN_W-1:0] gain_halfdb,
    output logic              gain_upd
);
    localparam int LINES_W = $bits(ser_lines_t);

    ser_lines_t raw_lines;
    ser_lines_t sync_lines;
    capture_t   cap;
    code_t      code_q;
    halfdb_t    halfdb_q;

    assign raw_lines = '{sck: ser_clk, sen_n: ser_en_n, sdi: ser_data};

    gs_sync #(
        .W      (LINES_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(LINES_W'(SER_IDLE))
    ) i_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_lines),
        .q  (sync_lines)
    );

    gs_shifter i_shift (
        .clk  (clk),
        .rst  (rst),
        .lines(sync_lines),
        .cap  (cap)
    );

    gs_gain_map i_map (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .code  (code_q),
        .halfdb(halfdb_q),
        .upd   (gain_upd)
    );

    assign gain_code   = code_q;
    assign gain_halfdb = halfdb_q;

    // R9: one cycle out of reset the outputs show the minimum setting
    p_reset_state_r9: assert property (@(posedge clk)
        $fell(rst) |-> (code_q == code_t'(MIN_CODE)) && !gain_upd);
endmodule

// File: tb/test_serial_gain_reg.sv
module test_serial_gain_reg;
    localparam time CLK_PERIOD = 10ns;
    localparam int  HOLD       = 4;
    localparam int  WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_en_n = 1'b1;
    logic       ser_data = 1'b0;
    logic [5:0] gain_code;
    logic [7:0] gain_halfdb;
    logic       gain_upd;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_gain_reg i_serial_gain_reg (
        .clk(clk), .rst(rst),
        .ser_clk(ser_clk), .ser_en_n(ser_en_n), .ser_data(ser_data),
        .gain_code(gain_code), .gain_halfdb(gain_halfdb), .gain_upd(gain_upd)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int v);
        int c = v % 64;
        if (c == 0) return 1;
        if (c > 60) return 60;
        return c;
    endfunction

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // frame with nbits bits MSB first; checks the active code stays put (R8)
    task automatic send_frame(input int value, input int nbits, input int old_code);
        ser_en_n = 1'b0;
        wait_neg(HOLD);
        for (int b = nbits - 1; b >= 0; b--) begin
            ser_data = value[b];
            ser_clk  = 1'b0;
            wait_neg(HOLD);
            ser_clk  = 1'b1;
            wait_neg(HOLD);
            check(gain_code == 6'(old_code), "R8 code held mid-frame", gain_code, old_code);
        end
        ser_clk = 1'b0;
        wait_neg(HOLD);
    endtask

    // raise enable and check latency, value, half-dB and pulse width
    task automatic close_frame(input int old_code, input int new_code, input string req);
        int hd = 2 * new_code - 53;
        ser_en_n = 1'b1;
        wait_neg(2);
        check(gain_code == 6'(old_code) && !gain_upd, "R8 no load before 3 clocks",
              gain_code, old_code);
        wait_neg(1);
        check(gain_code == 6'(new_code), req, gain_code, new_code);
        check($signed(gain_halfdb) == hd, "R7 half-dB value", $signed(gain_halfdb), hd);
        check(gain_upd == 1'b1, "R10 pulse with load", gain_upd, 1);
        wait_neg(1);
        check(gain_upd == 1'b0, "R10 pulse one cycle", gain_upd, 0);
        wait_neg(HOLD);
    endtask

    initial begin : watchdog
        while (cycles < WATCHDOG && !done) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int cur;
        wait_neg(3);
        rst = 1'b0;
        wait_neg(1);
        // R9 reset state
        check(gain_code == 6'd1, "R9 reset code", gain_code, 1);
        check($signed(gain_halfdb) == -51, "R9 reset half-dB", $signed(gain_halfdb), -51);
        check(gain_upd == 1'b0, "R9 reset pulse", gain_upd, 0);
        cur = 1;

        // R2 R4 R5 R6: every 6-bit code, MSB first
        for (int v = 0; v < 64; v++) begin
            string req;
            req = (v == 0) ? "R6 zero to min" : (v > 60) ? "R5 clamp to 60" : "R4 R2 code passes";
            send_frame(v, 6, cur);
            close_frame(cur, exp_code(v), req);
            cur = exp_code(v);
        end

        // R3: 8-bit words keep last six bits
        send_frame(75, 8, cur);
        close_frame(cur, 11, "R3 75 gives 11");
        cur = 11;
        for (int v = 64; v < 256; v += 37) begin
            send_frame(v, 8, cur);
            close_frame(cur, exp_code(v), "R3 upper bits dropped");
            cur = exp_code(v);
        end

        // R1: serial clocks with enable high are ignored
        send_frame(6'b100110, 6, cur);
        close_frame(cur, 38, "R1 setup load");
        cur = 38;
        for (int b = 0; b < 6; b++) begin
            ser_data = b[0];
            ser_clk  = 1'b1;
            wait_neg(HOLD);
            ser_clk  = 1'b0;
            wait_neg(HOLD);
            check(gain_code == 6'd38 && !gain_upd, "R1 no effect while idle", gain_code, 38);
        end
        send_frame(0, 0, cur);
        close_frame(cur, 38, "R1 empty frame reloads old word");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule